// File: doc/BRIEF.md
# Burst Address Generator with Selectable Beat Order

This block produces the word address that a synchronous burst memory array uses during a four-beat access. An access starts on a clock edge where an address strobe is seen while the device is selected. There are two strobes, one from a processor and one from a cache controller. On that edge the block captures the whole input address. The two low bits become the start offset of a wrapping burst. Each later edge with the advance strobe asserted moves to the next beat. With advance deasserted the current beat is held, which suspends the burst.

The beat order is chosen at run time by an order-select input that is meant to be strapped. Linear order adds the beat count to the start offset modulo four. Interleaved order XORs the beat count into the start offset. Both orders come from one beat counter. A strobe seen while the device is not selected ends the current burst. A one-cycle load flag tells which strobe started the access.

Top module: `burst_addr_gen`

## Requirements
- R1: An access loads only on an edge where all three enables are active: `ceOneN` low, `ceTwo` high and `ceThreeN` low.
- R2: On a load edge, `arrayAddr` takes the full `addrIn` value in the following cycle and the beat count restarts at zero. Exactly one of `loadProc` or `loadCtrl` is high for that one cycle.
- R3: When both strobes are low on the same selected edge, the processor strobe wins: `loadProc`=1 and `loadCtrl`=0.
- R4: `strobeProcN` has no effect while `ceOneN` is high. No load happens and the address is unchanged.
- R5: A strobe seen on an edge where the enables are not all active ends the burst. Later advance edges leave `arrayAddr` unchanged until the next load.
- R6: With `orderSel`=0 (linear), the low two address bits equal (start + beats) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R7: With `orderSel`=1 (interleaved), the low two bits equal start XOR beats. For example, start 01 gives 01, 00, 11, 10.
- R8: The beat count moves on an edge only when `advanceN` is low. With `advanceN` high the address is held.
- R9: After the fourth beat the low bits wrap back to the start offset, and the upper address bits never change during a burst.
- R10: `orderSel` is registered on every edge and affects `arrayAddr` from the cycle after the edge that sampled it. Its value after reset is 1 (interleaved).
- R11: A synchronous reset gives `arrayAddr`=0 and both load flags 0, and leaves no burst active. Advance edges before the first load have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | Word address presented with a strobe |
| ceOneN | input | 1 | Select enable, active low, also gates the processor strobe |
| ceTwo | input | 1 | Select enable, active high |
| ceThreeN | input | 1 | Select enable, active low |
| strobeProcN | input | 1 | Processor address strobe, active low, higher priority |
| strobeCtrlN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Advance to next beat, active low |
| orderSel | input | 1 | Beat order strap: 0 linear, 1 interleaved |
| arrayAddr | output | ADDR_W | Current word address for the array |
| loadProc | output | 1 | One-cycle flag: access started by processor strobe |
| loadCtrl | output | 1 | One-cycle flag: access started by controller strobe |

## Verification
The hardest state to reach from the ports is a burst that has been ended by a deselecting strobe and then receives advance edges. Another hard state is a mode change in the middle of a burst with a non-zero beat count. Random stimulus rarely combines a load, a deselect and a run of advances in the right order. Directed sequences build each case step by step: load, advance, deselect or flip the order strap, then advance. A long random phase runs with low strobe and enable rates, so that bursts survive many beats and wrap more than once.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Strobes from control to datapath, one edge at a time
  typedef struct packed {
    logic load;      // capture address, restart beat count
    logic fromProc;  // load came from the processor strobe
    logic step;      // advance beat count
    logic stop;      // burst ended by a deselecting strobe
  } burstCtl_t;

endpackage

// File: rtl/burst_order.sv
module burst_order #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] startOfs,
  input  logic [BEAT_W-1:0] beatCnt,
  input  logic              interleave,
  output logic [BEAT_W-1:0] lowBits
);

  logic [BEAT_W-1:0] linBits;
  logic [BEAT_W-1:0] xorBits;

  // Per-bit XOR for the interleaved order
  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xorBits[b] = startOfs[b] ^ beatCnt[b];
  end

  // Modulo 2^BEAT_W sum for the linear order
  assign linBits = startOfs + beatCnt;

  always_comb begin
    if (interleave) lowBits = xorBits;
    else            lowBits = linBits;
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ceOneN,
  input  logic      ceTwo,
  input  logic      ceThreeN,
  input  logic      strobeProcN,
  input  logic      strobeCtrlN,
  input  logic      advanceN,
  output burstCtl_t ctl,
  output logic      loadProc,
  output logic      loadCtrl
);

  logic selected;
  logic procSeen;
  logic ctrlSeen;
  logic burstActive;

  assign selected = !ceOneN && ceTwo && !ceThreeN;
  // processor strobe counts only while enable 1 is active
  assign procSeen = !strobeProcN && !ceOneN;
  assign ctrlSeen = !strobeCtrlN;

  always_comb begin
    ctl = '0;
    if (procSeen) begin
      ctl.load     = selected;
      ctl.fromProc = selected;
      ctl.stop     = !selected;
    end else if (ctrlSeen) begin
      ctl.load = selected;
      ctl.stop = !selected;
    end else begin
      ctl.step = burstActive && !advanceN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burstActive <= 1'b0;
      loadProc    <= 1'b0;
      loadCtrl    <= 1'b0;
    end else begin
      loadProc <= ctl.load && ctl.fromProc;
      loadCtrl <= ctl.load && !ctl.fromProc;
      if (ctl.load)      burstActive <= 1'b1;
      else if (ctl.stop) burstActive <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              orderSel,
  input  burstCtl_t         ctl,
  output logic [ADDR_W-1:0] arrayAddr
);

  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   baseHigh;
  logic [BEAT_W-1:0] startOfs;
  logic [BEAT_W-1:0] beatCnt;
  logic              modeReg;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseHigh <= '0;
      startOfs <= '0;
      beatCnt  <= '0;
      modeReg  <= 1'b1;
    end else begin
      modeReg <= orderSel;
      if (ctl.load) begin
        baseHigh <= addrIn[ADDR_W-1:BEAT_W];
        startOfs <= addrIn[BEAT_W-1:0];
        beatCnt  <= '0;
      end else if (ctl.step) begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  burst_order #(.BEAT_W(BEAT_W)) u_order (
    .startOfs  (startOfs),
    .beatCnt   (beatCnt),
    .interleave(modeReg),
    .lowBits   (lowBits)
  );

  assign arrayAddr = {baseHigh, lowBits};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceOneN,
  input  logic              ceTwo,
  input  logic              ceThreeN,
  input  logic              strobeProcN,
  input  logic              strobeCtrlN,
  input  logic              advanceN,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic              loadProc,
  output logic              loadCtrl
);

  burstCtl_t ctl;

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ceOneN     (ceOneN),
    .ceTwo      (ceTwo),
    .ceThreeN   (ceThreeN),
    .strobeProcN(strobeProcN),
    .strobeCtrlN(strobeCtrlN),
    .advanceN   (advanceN),
    .ctl        (ctl),
    .loadProc   (loadProc),
    .loadCtrl   (loadCtrl)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .addrIn   (addrIn),
    .orderSel (orderSel),
    .ctl      (ctl),
    .arrayAddr(arrayAddr)
  );

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addrIn,
  input logic              ceOneN,
  input logic              ceTwo,
  input logic              ceThreeN,
  input logic              strobeProcN,
  input logic              strobeCtrlN,
  input logic              advanceN,
  input logic              orderSel,
  input logic [ADDR_W-1:0] arrayAddr,
  input logic              loadProc,
  input logic              loadCtrl
);

  logic live1;
  logic live2;
  logic enOk;

  assign enOk = !ceOneN && ceTwo && !ceThreeN;

  always_ff @(posedge clk) begin
    if (rst) begin
      live1 <= 1'b0;
      live2 <= 1'b0;
    end else begin
      live1 <= 1'b1;
      live2 <= live1;
    end
  end

  assert_load_needs_enables_R1: assert property (@(posedge clk) disable iff (rst)
    live1 && (loadProc || loadCtrl) |-> $past(enOk));

  assert_load_captures_addr_R2: assert property (@(posedge clk) disable iff (rst)
    live1 && (loadProc || loadCtrl) |-> arrayAddr == $past(addrIn));

  assert_single_load_flag_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({loadProc, loadCtrl}));

  assert_proc_wins_R3: assert property (@(posedge clk) disable iff (rst)
    live1 && $past(!strobeProcN && !strobeCtrlN && enOk) |-> loadProc && !loadCtrl);

  assert_ce1_blocks_proc_R4: assert property (@(posedge clk) disable iff (rst)
    live1 && $past(ceOneN) |-> !loadProc && !loadCtrl);

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    live2 && $past(advanceN && strobeProcN && strobeCtrlN)
      && ($past(orderSel) == $past(orderSel, 2)) |-> $stable(arrayAddr));

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
    live2 && $past(strobeProcN && strobeCtrlN && !orderSel) && !$past(orderSel, 2)
      && (arrayAddr != $past(arrayAddr))
      |-> arrayAddr[BEAT_W-1:0] == BEAT_W'($past(arrayAddr[BEAT_W-1:0]) + 1'b1));

  assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    live1 && $past(strobeProcN && strobeCtrlN)
      |-> arrayAddr[ADDR_W-1:BEAT_W] == $past(arrayAddr[ADDR_W-1:BEAT_W]));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addrIn     (addrIn),
  .ceOneN     (ceOneN),
  .ceTwo      (ceTwo),
  .ceThreeN   (ceThreeN),
  .strobeProcN(strobeProcN),
  .strobeCtrlN(strobeCtrlN),
  .advanceN   (advanceN),
  .orderSel   (orderSel),
  .arrayAddr  (arrayAddr),
  .loadProc   (loadProc),
  .loadCtrl   (loadCtrl)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int ADDR_W = 15;
  localparam int BEAT_W = 2;
  localparam int HI_W   = ADDR_W - BEAT_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              ceOneN = 1'b1, ceTwo = 1'b0, ceThreeN = 1'b1;
  logic              strobeProcN = 1'b1, strobeCtrlN = 1'b1, advanceN = 1'b1;
  logic              orderSel = 1'b1;
  logic [ADDR_W-1:0] arrayAddr;
  logic              loadProc, loadCtrl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [HI_W-1:0]   refBase = '0;
  logic [BEAT_W-1:0] refStart = '0, refCnt = '0;
  logic              refMode = 1'b1, refActive = 1'b0;
  logic              refLp = 1'b0, refLc = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dut (
    .clk(clk), .rst(rst), .addrIn(addrIn), .ceOneN(ceOneN), .ceTwo(ceTwo),
    .ceThreeN(ceThreeN), .strobeProcN(strobeProcN), .strobeCtrlN(strobeCtrlN),
    .advanceN(advanceN), .orderSel(orderSel), .arrayAddr(arrayAddr),
    .loadProc(loadProc), .loadCtrl(loadCtrl)
  );

  function automatic logic [ADDR_W-1:0] expAddr();
    logic [BEAT_W-1:0] lo;
    lo = refMode ? (refStart ^ refCnt) : BEAT_W'(refStart + refCnt);
    return {refBase, lo};
  endfunction

  task automatic modelStep();
    logic sel, procSeen;
    refLp = 1'b0; refLc = 1'b0;
    if (rst) begin
      refBase = '0; refStart = '0; refCnt = '0; refMode = 1'b1; refActive = 1'b0;
      return;
    end
    sel      = !ceOneN && ceTwo && !ceThreeN;
    procSeen = !strobeProcN && !ceOneN;
    refMode  = orderSel;
    if (procSeen || !strobeCtrlN) begin
      if (sel) begin
        refBase = addrIn[ADDR_W-1:BEAT_W]; refStart = addrIn[BEAT_W-1:0];
        refCnt = '0; refActive = 1'b1;
        if (procSeen) refLp = 1'b1; else refLc = 1'b1;
      end else begin
        refActive = 1'b0;
      end
    end else if (!advanceN && refActive) begin
      refCnt = refCnt + 1'b1;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compareModel(input string req);
    check(arrayAddr == expAddr(), req, arrayAddr, expAddr());
    check({loadProc, loadCtrl} == {refLp, refLc}, req,
          ADDR_W'({loadProc, loadCtrl}), ADDR_W'({refLp, refLc}));
  endtask

  task automatic drv(input logic [ADDR_W-1:0] a, input logic c1n, input logic c2,
                     input logic c3n, input logic spn, input logic scn,
                     input logic avn, input logic ord);
    addrIn = a; ceOneN = c1n; ceTwo = c2; ceThreeN = c3n;
    strobeProcN = spn; strobeCtrlN = scn; advanceN = avn; orderSel = ord;
  endtask

  task automatic cycle(input string req);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareModel(req);
  endtask

  task automatic expectLow(input logic [BEAT_W-1:0] lo, input string req);
    check(arrayAddr[BEAT_W-1:0] == lo, req, ADDR_W'(arrayAddr[BEAT_W-1:0]), ADDR_W'(lo));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedInit;
    seedInit = $urandom(32'h5eed_0042);
    rst = 1'b1;
    repeat (3) cycle("R11");
    @(negedge clk);
    rst = 1'b0;
    check(arrayAddr == '0, "R11", arrayAddr, '0);
    check(!loadProc && !loadCtrl, "R11", ADDR_W'({loadProc, loadCtrl}), '0);
    // advance before any load: no effect
    drv('0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    repeat (2) cycle("R11");
    check(arrayAddr == '0, "R11", arrayAddr, '0);

    // linear from offset 10
    drv('0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    cycle("R10");
    drv(15'h1236, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    cycle("R2");
    check(arrayAddr == 15'h1236 && loadCtrl, "R2", arrayAddr, 15'h1236);
    drv('0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    cycle("R6"); expectLow(2'b11, "R6");
    cycle("R6"); expectLow(2'b00, "R6");
    cycle("R6"); expectLow(2'b01, "R6");
    cycle("R9"); expectLow(2'b10, "R9");
    check(arrayAddr[ADDR_W-1:BEAT_W] == 15'h1236 >> 2, "R9",
          ADDR_W'(arrayAddr[ADDR_W-1:BEAT_W]), 15'h1236 >> 2);

    // interleaved from offset 01
    drv(15'h0A51, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    cycle("R2");
    check(loadProc && !loadCtrl, "R2", ADDR_W'({loadProc, loadCtrl}), 15'd2);
    drv('0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    cycle("R7"); expectLow(2'b00, "R7");
    cycle("R7"); expectLow(2'b11, "R7");
    cycle("R7"); expectLow(2'b10, "R7");
    cycle("R9"); expectLow(2'b01, "R9");
    cycle("R7"); expectLow(2'b00, "R7");

    // suspend
    drv('0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    cycle("R8"); cycle("R8");
    expectLow(2'b00, "R8");

    // mode flip mid-burst: start 01 count 1, linear -> 10
    drv('0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    cycle("R10"); expectLow(2'b10, "R10");

    // both strobes: processor wins
    drv(15'h7FFC, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    cycle("R3");
    check(loadProc && !loadCtrl && arrayAddr == 15'h7FFC, "R3", arrayAddr, 15'h7FFC);

    // processor strobe with enable 1 high is ignored
    drv(15'h0123, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    cycle("R4");
    check(!loadProc && arrayAddr == 15'h7FFC, "R4", arrayAddr, 15'h7FFC);

    // controller strobe with enable 2 low: no load
    drv(15'h0123, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    cycle("R1");
    check(!loadCtrl && arrayAddr == 15'h7FFC, "R1", arrayAddr, 15'h7FFC);

    // deselect ends the burst: advance afterwards does nothing
    drv(15'h0040, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    cycle("R2");
    drv('0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    cycle("R5");
    drv('0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    cycle("R5"); cycle("R5");
    check(arrayAddr == 15'h0040, "R5", arrayAddr, 15'h0040);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic ord;
      ord = (i / 500) % 2 == 0;
      drv(ADDR_W'($urandom), ($urandom % 8) == 0, ($urandom % 8) != 0,
          ($urandom % 8) == 0, ($urandom % 6) != 0, ($urandom % 6) != 0,
          ($urandom % 3) == 0, ord);
      cycle(ord ? "R7" : "R6");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule